// File: doc/BRIEF.md
# Zero-Wait AHB SRAM Port

This block is an AHB-Lite slave that puts a single-port synchronous SRAM of 4096 words by 32 bits (16 kB) on a system bus. It takes byte, half-word and word transfers. It turns the address, size and direction of each accepted transfer into per-byte write enables. Reads return data in the data phase with no wait states. The array is a behavioural memory inside the block.

A write is held for one cycle. Its address and lane enables are registered in the address phase. The data is taken from the bus in the data phase, and the array is written at the close of that same cycle. That cycle is also the address phase of whatever follows the write. A read that arrives then finds the single port busy. The block lowers its ready output for exactly one cycle and issues the read in that wait cycle. Because the write has already landed, the read returns the new bytes. Each instance is a separate slave, so two copies can serve two masters at once.

Top module: `ahb_sram_port`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `hreadyout` is 1 and `hresp` is 0.
- R2: A word write (`hsize`=2) followed later by a word read of the same address returns the written 32-bit value.
- R3: A byte write (`hsize`=0) changes only the lane selected by `haddr[1:0]`; lane n is bits 8n+7:8n of the word. The other three bytes keep their values.
- R4: A half-word write (`hsize`=1) changes bits 15:0 when `haddr[1]` is 0 and bits 31:16 when it is 1. The other half keeps its value.
- R5: A read that does not directly follow a write completes with no wait state. Its data is on `hrdata` in the cycle after its address phase.
- R6: A read whose address phase directly follows an accepted write gets exactly one wait state (`hreadyout` low for one cycle). It returns data that includes that write, whether the address matches or not.
- R7: Back-to-back writes complete with no wait states.
- R8: A transfer is accepted only when `hsel`, `hready` and an NONSEQ or SEQ `htrans` (`htrans[1]`=1) are present together. IDLE (00), BUSY (01) or deselected cycles leave the array untouched, even with `hwrite` high and data on `hwdata`.
- R9: `hresp` is 0 (OKAY) for every transfer.
- R10: Back-to-back reads complete with no wait states, each returning its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Byte address; bits ADDR_W+1:2 pick the word |
| htrans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | 0 byte, 1 half-word, 2 word |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready | input | 1 | Bus ready, high when the previous data phase ends |
| hreadyout | output | 1 | Low for one cycle on a read right after a write |
| hresp | output | 1 | Always OKAY (0) |
| hrdata | output | 32 | Read data, valid in the data phase when `hreadyout` is high |

## Verification
A held write that never reaches the array shows up as stale data on the first later read of that word. With a scoreboard that read is at most a few cycles away. Wrong lane enables corrupt neighbouring bytes, and the next word read shows this. A stall flag that sticks or fires at the wrong time shows on `hreadyout` within one cycle: a missing wait, an extra wait, or a wait after a write or an idle.

// File: rtl/ahb_sram_port.sv
module ahb_sram_port #(
  parameter int ADDR_W = 12
) (
  input  logic        hclk,
  input  logic        hresetn,
  input  logic        hsel,
  input  logic [31:0] haddr,
  input  logic [1:0]  htrans,
  input  logic        hwrite,
  input  logic [2:0]  hsize,
  input  logic [31:0] hwdata,
  input  logic        hready,
  output logic        hreadyout,
  output logic        hresp,
  output logic [31:0] hrdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [31:0]       mem [DEPTH];
  logic [31:0]       rdata_q;
  logic              wr_q, stall_q;
  logic [ADDR_W-1:0] wr_idx, rd_idx_q;
  logic [3:0]        wr_be, be;

  wire              acc      = hsel & hready & htrans[1];
  wire [ADDR_W-1:0] widx     = haddr[ADDR_W+1:2];
  wire              conflict = acc & ~hwrite & wr_q;
  wire              rd_now   = acc & ~hwrite & ~wr_q;

  logic unused_bits;
  assign unused_bits = ^{haddr[31:ADDR_W+2], hsize[2], htrans[0]};

  always_comb begin
    case (hsize[1:0])
      2'd0:    be = 4'b0001 << haddr[1:0];
      2'd1:    be = haddr[1] ? 4'b1100 : 4'b0011;
      default: be = 4'b1111;
    endcase
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      wr_q     <= 1'b0;
      stall_q  <= 1'b0;
      wr_idx   <= '0;
      wr_be    <= '0;
      rd_idx_q <= '0;
    end else begin
      stall_q <= conflict;
      if (conflict) rd_idx_q <= widx;
      if (hready) begin
        wr_q <= acc & hwrite;
        if (acc & hwrite) begin
          wr_idx <= widx;
          wr_be  <= be;
        end
      end
    end
  end

  always_ff @(posedge hclk) begin
    if (wr_q) begin
      for (int i = 0; i < 4; i++)
        if (wr_be[i]) mem[wr_idx][8*i +: 8] <= hwdata[8*i +: 8];
    end
    if (rd_now)       rdata_q <= mem[widx];
    else if (stall_q) rdata_q <= mem[rd_idx_q];
  end

  assign hreadyout = ~stall_q;
  assign hresp     = 1'b0;
  assign hrdata    = rdata_q;

  // R6
  stall_single_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    !hreadyout |=> hreadyout);

  // R6
  stall_cause_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    $fell(hreadyout) |-> $past(hsel && hready && htrans[1] && !hwrite && wr_q));

  // R5
  read_nowait_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (acc && !hwrite && !wr_q) |=> hreadyout);

  // R7
  write_nowait_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (acc && hwrite) |=> hreadyout);

  // R8
  idle_nowait_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (hready && !(hsel && htrans[1])) |=> hreadyout);
endmodule

// File: tb/ahb_sram_port_bench.sv
module ahb_sram_port_bench;
  logic clk = 1'b0, rstn = 1'b0;
  always #10 clk = ~clk;

  logic        hsel = 1'b0, hwrite = 1'b0;
  logic [31:0] haddr = '0, hwdata = '0;
  logic [1:0]  htrans = 2'b00;
  logic [2:0]  hsize = 3'd2;
  logic        hreadyout, hresp;
  logic [31:0] hrdata;

  ahb_sram_port u_ahb_sram_port (
    .hclk(clk), .hresetn(rstn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hreadyout),
    .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata)
  );

  typedef struct {
    bit          rd;
    logic [31:0] data;
    int          waits;
    string       req;
  } item_t;

  item_t       sb[$];
  logic [31:0] model [int];
  int          checks = 0, fails = 0;
  bit          prev_w = 0, done = 0;
  logic [31:0] wd_next = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] lanes(input logic [2:0] sz, input logic [1:0] lo);
    case (sz[1:0])
      2'd0:    return 4'b0001 << lo;
      2'd1:    return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic xfer(input bit w, input logic [31:0] a, input logic [2:0] sz,
                      input logic [31:0] d, input string req,
                      input logic [1:0] tr = 2'b10, input bit sel = 1'b1);
    item_t       it;
    int          idx;
    logic [31:0] cur;
    logic [3:0]  be;
    @(negedge clk);
    hsel = sel; htrans = tr; hwrite = w; haddr = a; hsize = sz; hwdata = wd_next;
    idx = int'(a[13:2]);
    if (sel && tr[1]) begin
      it.rd = !w; it.req = req; it.waits = (!w && prev_w) ? 1 : 0;
      cur = model.exists(idx) ? model[idx] : 32'h0;
      if (w) begin
        be = lanes(sz, a[1:0]);
        for (int i = 0; i < 4; i++) if (be[i]) cur[8*i +: 8] = d[8*i +: 8];
        model[idx] = cur;
        it.data = '0;
      end else begin
        it.data = cur;
      end
      sb.push_back(it);
      prev_w = w;
    end else begin
      prev_w = 1'b0;
    end
    wd_next = d;
    while (!hreadyout) @(negedge clk);
  endtask

  // monitor: samples 4 ns after each falling edge
  initial begin
    bit    dp_act;
    int    waits;
    item_t cur;
    dp_act = 0; waits = 0;
    forever begin
      @(negedge clk); #4;
      if (!rstn) begin
        dp_act = 0;
      end else begin
        if (dp_act) begin
          if (!hreadyout) waits++;
          else begin
            check(waits == cur.waits, cur.req, "wait states", waits, cur.waits);
            if (cur.rd) check(hrdata === cur.data, cur.req, "read data", hrdata, cur.data);
            check(hresp === 1'b0, "R9", "hresp", {31'b0, hresp}, 32'h0);
            dp_act = 0;
          end
        end
        if (hreadyout && hsel && htrans[1]) begin
          if (sb.size() == 0) check(1'b0, "R8", "unexpected acceptance", haddr, 32'h0);
          else begin
            cur = sb.pop_front(); dp_act = 1; waits = 0;
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: ready and OKAY while in reset
    check(hreadyout === 1'b1, "R1", "hreadyout in reset", {31'b0, hreadyout}, 32'h1);
    check(hresp === 1'b0, "R1", "hresp in reset", {31'b0, hresp}, 32'h0);
    rstn = 1'b1;
    @(negedge clk);
    check(hreadyout === 1'b1, "R1", "hreadyout after reset", {31'b0, hreadyout}, 32'h1);

    // R2: word write, idle, read back
    xfer(1, 32'h10, 3'd2, 32'hDEADBEEF, "R2");
    xfer(0, 32'h0, 3'd2, 32'h0, "R2", 2'b00);
    xfer(0, 32'h10, 3'd2, 32'h0, "R2");

    // R7: back-to-back writes
    xfer(1, 32'h20, 3'd2, 32'hA1A1A1A1, "R7");
    xfer(1, 32'h24, 3'd2, 32'hA2A2A2A2, "R7");
    xfer(1, 32'h28, 3'd2, 32'hA3A3A3A3, "R7");
    xfer(0, 32'h0, 3'd2, 32'h0, "R7", 2'b00);

    // R10 / R5: back-to-back reads, no stall
    xfer(0, 32'h20, 3'd2, 32'h0, "R10");
    xfer(0, 32'h24, 3'd2, 32'h0, "R10");
    xfer(0, 32'h28, 3'd2, 32'h0, "R5");

    // R6: read right after write, same and different address
    xfer(1, 32'h30, 3'd2, 32'h11223344, "R6");
    xfer(0, 32'h30, 3'd2, 32'h0, "R6");
    xfer(0, 32'h10, 3'd2, 32'h0, "R5");
    xfer(1, 32'h34, 3'd2, 32'h55667788, "R6");
    xfer(0, 32'h20, 3'd2, 32'h0, "R6");
    xfer(0, 32'h34, 3'd2, 32'h0, "R5");

    // R3: byte lanes
    xfer(1, 32'h40, 3'd2, 32'hAABBCCDD, "R3");
    xfer(0, 32'h0, 3'd2, 32'h0, "R3", 2'b00);
    xfer(1, 32'h41, 3'd0, 32'h00005500, "R3");
    xfer(1, 32'h43, 3'd0, 32'h77000000, "R3");
    xfer(0, 32'h40, 3'd2, 32'h0, "R3");

    // R4: half-word lanes
    xfer(1, 32'h50, 3'd2, 32'h12345678, "R4");
    xfer(1, 32'h52, 3'd1, 32'hCAFE0000, "R4");
    xfer(0, 32'h0, 3'd2, 32'h0, "R4", 2'b00);
    xfer(1, 32'h50, 3'd1, 32'h0000BEEF, "R4");
    xfer(0, 32'h0, 3'd2, 32'h0, "R4", 2'b00);
    xfer(0, 32'h50, 3'd2, 32'h0, "R4");

    // R8: IDLE, BUSY and deselected writes do nothing
    xfer(1, 32'h60, 3'd2, 32'h0F0F0F0F, "R8");
    xfer(1, 32'h60, 3'd2, 32'hFFFFFFFF, "R8", 2'b00);
    xfer(1, 32'h60, 3'd2, 32'hEEEEEEEE, "R8", 2'b01);
    xfer(1, 32'h60, 3'd2, 32'hDDDDDDDD, "R8", 2'b10, 1'b0);
    xfer(0, 32'h0, 3'd2, 32'h0, "R8", 2'b00);
    xfer(0, 32'h60, 3'd2, 32'h0, "R8");

    xfer(0, 32'h0, 3'd2, 32'h0, "R8", 2'b00, 1'b0);
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2", "outstanding transfers", sb.size(), 32'h0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule